// File: doc/BRIEF.md
# Redundant Clock Failover Selector

This block picks one of two reference clocks and passes it to a single clock output. A static strap input names the primary reference. The other reference is the backup. A free-running detection clock, which is much faster than either reference, watches both references for rising edges. A reference is marked lost when no rising edge arrives within a set window of detection-clock cycles.

When the primary is lost, the output moves to the backup. The move is made by two gating legs. The old leg is closed on a falling edge of its own clock. The new leg opens on a falling edge of the backup clock. A settle interval between the two steps makes sure both legs are never open at the same time. When the primary comes back, it must first deliver a long run of counted rising edges. Only then does the output return to it. If the primary drops out again during that run, the count starts over. If both references are lost, the output is held low and the status shows that no source is active.

Top module: `clk_failover_sel`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, `src_status` reads 2'b00 and `clk_out` is low. When both references are running after reset, the block settles on the primary: `src_status` reads 2'b01 for reference A and 2'b10 for reference B, and `clk_out` toggles with that reference.
- R2: With `sel_a_primary` high, reference A is the primary. With it low, reference B is the primary. The strap is sampled as static and may only change while reset is held.
- R3: At most one gating leg is enabled at any time. When a source stops at its low level, every high and low phase seen on `clk_out` across a handover lasts at least as long as the shorter half period of the two references.
- R4: A source is lost once no rising edge arrives for `LOSS_WINDOW` (default 16) detection-clock cycles. If the primary is lost while the backup runs, `src_status` names the backup within 200 detection-clock cycles, and `clk_out` then toggles with the backup.
- R5: After the primary returns, the block does not switch back to it until `QUAL_EDGES` (default 1024) further primary rising edges have been counted. Once the count completes, it does switch back.
- R6: If the primary is lost at any point during the qualification count, the count restarts from zero.
- R7: If both references are lost, `src_status` reads 2'b00 and `clk_out` stays low.
- R8: If the backup is lost while the primary is active, there is no effect: `src_status` keeps naming the primary and `clk_out` keeps toggling.
- R9: `src_status` never names more than one source. It only moves to a source that was seen active in the cycle before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_det | input | 1 | Free-running detection clock |
| rst | input | 1 | Synchronous active-high reset, detection-clock domain |
| ref_a | input | 1 | Reference clock A |
| ref_b | input | 1 | Reference clock B |
| sel_a_primary | input | 1 | 1: A is primary, 0: B is primary |
| clk_out | output | 1 | Selected clock (gated OR of the two legs) |
| src_status | output | 2 | Active source, one-hot: bit0 = A, bit1 = B, 00 = none |

## Verification
The main function is exercised with four kinds of stimulus:
- Dropping each reference in turn, under both strap settings. This tells a correct failover apart from a wrong choice of primary.
- Dropping only the backup. This tells a correct "no effect" apart from a needless switch.
- Restoring the primary and sampling just before and just after the edge count completes. This tells a qualification that is too short apart from one that is correct.
- A restore that is interrupted by a short outage. This tells a count that restarts apart from one that carries over.

Seeded random trials vary the phase of the backup against the primary and the run length before each outage. Throughout, a pulse-width monitor on the output detects any shortened phase during handovers.

// File: rtl/cfs_pkg.sv
`timescale 1ns/1ps
package cfs_pkg;
  localparam int unsigned N_SRC = 2;
  typedef logic [N_SRC-1:0] src_vec_t;
  localparam src_vec_t SRC_NONE = 2'b00;
  localparam src_vec_t SRC_A    = 2'b01;
  localparam src_vec_t SRC_B    = 2'b10;
endpackage

// File: rtl/clk_activity_mon.sv
`timescale 1ns/1ps
// Samples one reference in the detection domain, flags its rising edges
// and reports whether an edge arrived within the last WINDOW cycles.
module clk_activity_mon #(
  parameter int unsigned WINDOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic rise,
  output logic alive
);
  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

  logic [2:0]    samp_q;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst) samp_q <= '0;
    else     samp_q <= {samp_q[1:0], ref_in};
  end

  assign rise = samp_q[1] & ~samp_q[2];

  always_ff @(posedge clk) begin
    if (rst)                  idle_cnt <= '0;
    else if (rise)            idle_cnt <= '0;
    else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
  end

  assign alive = (idle_cnt != LIMIT);
endmodule

// File: rtl/revert_qualifier.sv
`timescale 1ns/1ps
// Counts rising edges of a returning primary; any loss restarts the count.
module revert_qualifier #(
  parameter int unsigned QUAL_EDGES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_in,
  input  logic alive_in,
  output logic qual_ok
);
  localparam int unsigned QW = $clog2(QUAL_EDGES);
  localparam logic [QW-1:0] LAST = QW'(QUAL_EDGES - 1);

  logic [QW-1:0] edge_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt <= '0;
      qual_ok  <= 1'b1;
    end else if (!alive_in) begin
      edge_cnt <= '0;
      qual_ok  <= 1'b0;
    end else if (!qual_ok && edge_in) begin
      if (edge_cnt == LAST) begin
        edge_cnt <= '0;
        qual_ok  <= 1'b1;
      end else begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gated_clk_leg.sv
`timescale 1ns/1ps
// Enable path for one reference: request resynchronised on the reference's
// own falling edges, cleared at once when the reference is declared dead.
module gated_clk_leg #(
  parameter int unsigned STAGES = 2
) (
  input  logic ref_in,
  input  logic kill,
  input  logic req,
  output logic en
);
  logic [STAGES-1:0] stg;

  always_ff @(negedge ref_in or posedge kill) begin
    if (kill) stg <= '0;
    else      stg <= {stg[STAGES-2:0], req};
  end

  assign en = stg[STAGES-1];
endmodule

// File: rtl/clk_failover_sel.sv
`timescale 1ns/1ps
module clk_failover_sel
  import cfs_pkg::*;
#(
  parameter int unsigned LOSS_WINDOW   = 16,
  parameter int unsigned QUAL_EDGES    = 1024,
  parameter int unsigned SETTLE_CYCLES = 3 * LOSS_WINDOW
) (
  input  logic       clk_det,
  input  logic       rst,
  input  logic       ref_a,
  input  logic       ref_b,
  input  logic       sel_a_primary,
  output logic       clk_out,
  output logic [1:0] src_status
);
  localparam int unsigned SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [SW-1:0] SETTLE_MAX = SW'(SETTLE_CYCLES);

  src_vec_t refs;
  src_vec_t src_rise;
  src_vec_t src_alive;
  src_vec_t kill_q;
  src_vec_t leg_en;
  src_vec_t ack_s1, ack_q;
  src_vec_t pri_vec, sec_vec, target, req_nx, req_q, cur_q;
  logic     pri_alive, pri_rise, qual_ok;
  logic [SW-1:0] settle_cnt;

  assign refs = {ref_b, ref_a};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    clk_activity_mon #(.WINDOW(LOSS_WINDOW)) u_mon (
      .clk   (clk_det),
      .rst   (rst),
      .ref_in(refs[g]),
      .rise  (src_rise[g]),
      .alive (src_alive[g])
    );

    always_ff @(posedge clk_det) begin
      kill_q[g] <= rst | ~src_alive[g];
    end

    gated_clk_leg #(.STAGES(2)) u_leg (
      .ref_in(refs[g]),
      .kill  (kill_q[g]),
      .req   (req_q[g]),
      .en    (leg_en[g])
    );

    always_ff @(posedge clk_det) begin
      if (rst) begin
        ack_s1[g] <= 1'b0;
        ack_q[g]  <= 1'b0;
      end else begin
        ack_s1[g] <= leg_en[g];
        ack_q[g]  <= ack_s1[g];
      end
    end
  end

  assign pri_vec   = sel_a_primary ? SRC_A : SRC_B;
  assign sec_vec   = ~pri_vec;
  assign pri_alive = |(src_alive & pri_vec);
  assign pri_rise  = |(src_rise & pri_vec);

  revert_qualifier #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
    .clk     (clk_det),
    .rst     (rst),
    .edge_in (pri_rise),
    .alive_in(pri_alive),
    .qual_ok (qual_ok)
  );

  always_comb begin
    if (pri_alive && qual_ok)           target = pri_vec;
    else if (|(src_alive & sec_vec))    target = sec_vec;
    else                                target = SRC_NONE;
  end

  assign req_nx = (target == cur_q) ? cur_q : SRC_NONE;

  always_ff @(posedge clk_det) begin
    if (rst) begin
      req_q      <= SRC_NONE;
      cur_q      <= SRC_NONE;
      settle_cnt <= '0;
    end else begin
      req_q <= req_nx;
      if (req_nx != req_q)            settle_cnt <= '0;
      else if (settle_cnt != SETTLE_MAX) settle_cnt <= settle_cnt + 1'b1;
      if (target != cur_q && req_q == SRC_NONE && ack_q == SRC_NONE &&
          settle_cnt == SETTLE_MAX)
        cur_q <= target;
    end
  end

  assign src_status = cur_q;
  assign clk_out    = |(refs & leg_en);
endmodule

// File: rtl/clk_failover_sel_chk.sv
`timescale 1ns/1ps
module clk_failover_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] en,
  input logic [1:0] status,
  input logic [1:0] alive,
  input logic       qual_ok,
  input logic       sel_a,
  input logic       clk_out
);
  assert_single_leg_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en));

  assert_status_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(status));

  assert_move_to_alive_a_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> $past(alive[0]));

  assert_move_to_alive_b_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> $past(alive[1]));

  assert_revert_a_qualified_R5: assert property (@(posedge clk) disable iff (rst)
    (sel_a && $rose(status[0])) |-> $past(qual_ok));

  assert_revert_b_qualified_R5: assert property (@(posedge clk) disable iff (rst)
    (!sel_a && $rose(status[1])) |-> $past(qual_ok));

  assert_none_is_low_R7: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b00 && $past(status) == 2'b00) |-> !clk_out);
endmodule

bind clk_failover_sel clk_failover_sel_chk u_chk (
  .clk    (clk_det),
  .rst    (rst),
  .en     (leg_en),
  .status (src_status),
  .alive  (src_alive),
  .qual_ok(qual_ok),
  .sel_a  (sel_a_primary),
  .clk_out(clk_out)
);

// File: tb/clk_failover_sel_tb.sv
`timescale 1ns/1ps
module clk_failover_sel_tb;
  localparam real A_HALF = 20.0;
  localparam real B_HALF = 22.0;
  localparam int  QUAL   = 1024;

  logic clk_det = 1'b0;
  logic rst = 1'b1;
  logic ref_a = 1'b0, ref_b = 1'b0;
  logic sel_a_primary = 1'b1;
  logic clk_out;
  logic [1:0] src_status;
  logic a_run = 1'b0, b_run = 1'b0;

  int n_cmp = 0, n_bad = 0;
  int edge_cnt = 0, runt_cnt = 0;
  real last_t = 0.0;

  always #2.5 clk_det = ~clk_det;

  always begin
    if (a_run) begin ref_a = 1'b1; #(A_HALF); ref_a = 1'b0; #(A_HALF); end
    else begin ref_a = 1'b0; #1; end
  end
  always begin
    if (b_run) begin ref_b = 1'b1; #(B_HALF); ref_b = 1'b0; #(B_HALF); end
    else begin ref_b = 1'b0; #1; end
  end

  clk_failover_sel u_dut (
    .clk_det(clk_det), .rst(rst), .ref_a(ref_a), .ref_b(ref_b),
    .sel_a_primary(sel_a_primary), .clk_out(clk_out), .src_status(src_status)
  );

  always @(posedge clk_out) edge_cnt++;
  always @(clk_out) begin
    if (last_t > 0.0 && ($realtime - last_t) < A_HALF - 0.5) runt_cnt++;
    last_t = $realtime;
  end

  function automatic logic [1:0] exp_status(input logic sel, input logic a_on,
                                            input logic b_on, input logic qual);
    logic [1:0] pri = sel ? 2'b01 : 2'b10;
    logic p_on = sel ? a_on : b_on;
    logic s_on = sel ? b_on : a_on;
    if (p_on && qual) return pri;
    if (s_on)         return ~pri;
    return 2'b00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_det); rst = 1'b1;
    repeat (10) @(negedge clk_det);
    rst = 1'b0;
  endtask

  task automatic toggles_in(input int ns, output int n);
    int start = edge_cnt;
    #(ns);
    n = edge_cnt - start;
  endtask

  task automatic see_status(input string tag, input logic [1:0] exp);
    @(negedge clk_det);
    chk(tag, {30'd0, src_status}, {30'd0, exp});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_det);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int n, r0, lows;
    void'($urandom(32'd20240607));
    // R1: reset state, then settle on primary A
    a_run = 1; b_run = 1; sel_a_primary = 1;
    repeat (4) @(negedge clk_det);
    see_status("R1 reset status", 2'b00);
    chk("R1 reset clk_out low", {31'd0, clk_out}, 32'd0);
    do_reset();
    #2000;
    see_status("R1/R2 primary A", exp_status(1, 1, 1, 1));
    toggles_in(1000, n);
    chk("R1 clk_out toggles", {31'd0, n >= 20}, 32'd1);
    // R8: backup lost, no effect
    b_run = 0; #1000;
    see_status("R8 status kept", 2'b01);
    toggles_in(800, n);
    chk("R8 clk_out still toggles", {31'd0, n >= 15}, 32'd1);
    b_run = 1; #500;
    // R4 / R3: primary lost
    r0 = runt_cnt;
    a_run = 0; #1000;
    see_status("R4 failover to B", exp_status(1, 0, 1, 0));
    toggles_in(800, n);
    chk("R4 clk_out follows B", {31'd0, n >= 15}, 32'd1);
    // R5: qualification window
    a_run = 1; #(1000 * 2 * A_HALF);
    see_status("R5 not yet reverted", 2'b10);
    #((QUAL - 1000) * 2 * A_HALF + 2000);
    see_status("R5 reverted to A", 2'b01);
    chk("R3 no runt on handovers", runt_cnt - r0, 32'd0);
    // R6: loss during qualification restarts count
    a_run = 0; #1000;
    see_status("R6 on backup", 2'b10);
    a_run = 1; #(600 * 2 * A_HALF);
    a_run = 0; #400;
    a_run = 1; #(1000 * 2 * A_HALF);
    see_status("R6 count restarted", 2'b10);
    #((QUAL - 1000) * 2 * A_HALF + 2000);
    see_status("R6 reverted after full count", 2'b01);
    // R7: both lost
    a_run = 0; b_run = 0; #1000;
    see_status("R7 none", 2'b00);
    lows = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk_det); if (clk_out) lows++; end
    chk("R7 clk_out held low", lows, 32'd0);
    // R2: B primary
    sel_a_primary = 0; a_run = 1; b_run = 1;
    do_reset(); #2000;
    see_status("R2 primary B", exp_status(0, 1, 1, 1));
    r0 = runt_cnt;
    b_run = 0; #1000;
    see_status("R4 failover to A", exp_status(0, 1, 0, 0));
    chk("R3 no runt B to A", runt_cnt - r0, 32'd0);
    // random trials
    for (int t = 0; t < 8; t++) begin
      logic s;
      int ofs, pre;
      s = 1'($urandom_range(0, 1));
      ofs = $urandom_range(0, 43);
      pre = $urandom_range(50, 300);
      a_run = 0; b_run = 0; #200;
      sel_a_primary = s;
      a_run = 1; #(ofs); b_run = 1;
      do_reset(); #2000;
      repeat (pre) @(negedge clk_det);
      see_status("R1 random start", exp_status(s, 1, 1, 1));
      r0 = runt_cnt;
      if (s) a_run = 0; else b_run = 0;
      #1000;
      see_status("R4 random failover", exp_status(s, !s, s, 0));
      chk("R3 random no runt", runt_cnt - r0, 32'd0);
      if (s) b_run = 0; else a_run = 0;
      #1000;
      see_status("R7 random none", 2'b00);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule